// File: doc/BRIEF.md
# Six-Bit Bidirectional Pin Port

This block is a general-purpose pin port with six lines. Each line has its own bit in an output latch and in a direction register. The pad side gets an output value and an output enable for each line. The bus side sees three registers, selected by a two-bit address and reached through a write strobe and a read strobe.

Pin levels enter through a two-flop synchroniser. A read of the data register returns the synchronised pin levels, not the latch contents. Bit-set and bit-clear commands are read-modify-write operations: the six synchronised pin levels are taken, one bit is changed, and the result is written to the latch. Because of this, an input line's outside level is copied into its latch.

Lines that have an analog function start in analog mode. In analog mode the digital input is cut off and the line reads as zero. Line 4 has no analog function. It is an open-drain line that can only pull low, and its synchronised level is also brought out as a clock tap for a neighbouring timer.

Top module: `pinport`

## Requirements
- R1: When reset is released, every direction bit is 1, the output latch is 0, and `rd_data` is 0. The mode register equals the analog-capable mask `ANA_CAP` (default `6'b101111`, so every line except line 4 starts in analog mode).
- R2: For a line with direction bit 0, `pin_oe` is 1 and `pin_o` carries its latch bit. For a line with direction bit 1, `pin_oe` is 0.
- R3: The registers are addressed as follows: address 0 is port data, 1 is direction, 2 is mode, and 3 reads as 0 and cannot be written. `rd_data` is registered. It is loaded one clock after a cycle in which `rd_en` is high, and it holds its value otherwise.
- R4: A port-data read returns each pin level as it was two clocks before the read is sampled. A pin change made in the same cycle as the read strobe does not show up in that read.
- R5: A write with `wr_op`=0 (load) replaces the whole addressed register with `wr_data`. For the mode register, only the analog-capable bits are kept.
- R6: `wr_op`=1 (set) and `wr_op`=2 (clear) act on the bit at index `wr_bit`. On the data address, the result is the digital pin read value with only that bit changed, written to the latch. On the direction and mode addresses, the register's own value is modified. An index of 6 or 7, or `wr_op`=3, leaves every register unchanged.
- R7: Line 4 is open-drain. `pin_o[4]` is always 0, and `pin_oe[4]` is 1 only when direction bit 4 is 0 and latch bit 4 is 0.
- R8: `tmr_clk` equals the level of `pin_i[4]` from two clocks earlier.
- R9: A line whose mode bit is 1 returns 0 in port-data reads, and its outside level is 0 for set/clear commands.
- R10: Mode bits do not change `pin_oe` or `pin_o`. The drivers follow the direction and latch registers alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register select: 0 data, 1 direction, 2 mode, 3 none |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | 0 load, 1 set bit, 2 clear bit, 3 no operation |
| wr_bit | input | 3 | Bit index for set and clear |
| wr_data | input | 6 | Load value |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 6 | Registered read data |
| pin_i | input | 6 | Pad input levels |
| pin_o | output | 6 | Pad output values |
| pin_oe | output | 6 | Pad output enables, active high |
| tmr_clk | output | 1 | Synchronised line-4 level for the timer |

## Verification
The assertions check these relations on every cycle:
- no line is enabled while its direction bit is 1;
- the open-drain line is never enabled while its latch or direction bit is 1;
- the timer tap trails pin 4 by two clocks;
- analog-mode lines never read as 1;
- `rd_data` holds between reads;
- load, set and clear leave the latch with the commanded value, and out-of-range indices change nothing.

Only the bench's sweeps show the full value mapping. They cover every latch and direction pattern on the pads, every pin pattern through the read path with its exact latency, every mode pattern, and the read-modify-write behaviour. That last sweep confirms that outside levels, masked by analog mode, land in the latch.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_MODE = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_NOP  = 2'd3
   } wr_op_e;

endpackage

// File: rtl/pinport_sync.sv
module pinport_sync #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] meta_q;
   logic [WIDTH-1:0] stab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         stab_q <= '0;
      end else begin
         meta_q <= async_i;
         stab_q <= meta_q;
      end
   end

   assign sync_o = stab_q;

endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
   import pinport_pkg::*;
#(
   parameter int               WIDTH   = 6,
   parameter logic [WIDTH-1:0] ANA_CAP = 6'b101111,
   localparam int              IDX_W   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_sel_e         sel,
   input  wr_op_e           op,
   input  logic [IDX_W-1:0] bitsel,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pin_dig,
   output logic [WIDTH-1:0] lat_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] mode_q
);

   logic [31:0]      idx_ext;
   logic             idx_ok;
   logic             is_bitop;
   logic [WIDTH-1:0] bit_mask;
   logic [WIDTH-1:0] lat_d;
   logic [WIDTH-1:0] dir_d;
   logic [WIDTH-1:0] mode_d;

   assign idx_ext  = 32'(bitsel);
   assign idx_ok   = idx_ext < 32'(WIDTH);
   assign is_bitop = (op == OP_SET) || (op == OP_CLR);
   assign bit_mask = idx_ok ? (WIDTH'(1) << bitsel) : '0;

   function automatic logic [WIDTH-1:0] apply_op(
      input wr_op_e           o,
      input logic [WIDTH-1:0] base,
      input logic [WIDTH-1:0] load,
      input logic [WIDTH-1:0] msk,
      input logic             ok
   );
      logic [WIDTH-1:0] r;
      r = base;
      case (o)
         OP_LOAD: r = load;
         OP_SET:  if (ok) r = base | msk;
         OP_CLR:  if (ok) r = base & ~msk;
         default: r = base;
      endcase
      return r;
   endfunction

   always_comb begin
      lat_d  = lat_q;
      dir_d  = dir_q;
      mode_d = mode_q;
      if (wr_en) begin
         case (sel)
            SEL_DATA: begin
               if (op == OP_LOAD)
                  lat_d = wdata;
               else if (is_bitop && idx_ok)
                  lat_d = apply_op(op, pin_dig, wdata, bit_mask, idx_ok);
            end
            SEL_DIR:  dir_d  = apply_op(op, dir_q, wdata, bit_mask, idx_ok);
            SEL_MODE: mode_d = apply_op(op, mode_q, wdata, bit_mask, idx_ok) & ANA_CAP;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q  <= '0;
         dir_q  <= '1;
         mode_q <= ANA_CAP;
      end else begin
         lat_q  <= lat_d;
         dir_q  <= dir_d;
         mode_q <= mode_d;
      end
   end

   // R5
   load_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_DATA && op == OP_LOAD) |=> (lat_q == $past(wdata)));

   // R6
   set_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_DATA && op == OP_SET && idx_ok)
         |=> ((lat_q & $past(bit_mask)) != '0));

   // R6
   clr_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_DATA && op == OP_CLR && idx_ok)
         |=> ((lat_q & $past(bit_mask)) == '0));

   // R6
   bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_bitop && !idx_ok)
         |=> ($stable(lat_q) && $stable(dir_q) && $stable(mode_q)));

endmodule

// File: rtl/pinport_pad.sv
module pinport_pad #(
   parameter int WIDTH  = 6,
   parameter int OD_BIT = 4
) (
   input  logic [WIDTH-1:0] lat,
   input  logic [WIDTH-1:0] dir,
   output logic [WIDTH-1:0] drv_o,
   output logic [WIDTH-1:0] drv_oe
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      if (i == OD_BIT) begin : g_open_drain
         assign drv_o[i]  = 1'b0;
         assign drv_oe[i] = ~dir[i] & ~lat[i];
      end else begin : g_push_pull
         assign drv_o[i]  = lat[i];
         assign drv_oe[i] = ~dir[i];
      end
   end

endmodule

// File: rtl/pinport.sv
module pinport
   import pinport_pkg::*;
#(
   parameter int               WIDTH   = 6,
   parameter int               OD_BIT  = 4,
   parameter logic [WIDTH-1:0] ANA_CAP = 6'b101111,
   localparam int              IDX_W   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       addr,
   input  logic             wr_en,
   input  logic [1:0]       wr_op,
   input  logic [IDX_W-1:0] wr_bit,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] pin_o,
   output logic [WIDTH-1:0] pin_oe,
   output logic             tmr_clk
);

   if (WIDTH < 2 || WIDTH > 16) begin : g_bad_width
      $error("pinport: WIDTH out of range");
   end
   if (OD_BIT < 0 || OD_BIT >= WIDTH) begin : g_bad_od
      $error("pinport: OD_BIT outside the port");
   end else if (ANA_CAP[OD_BIT]) begin : g_bad_cap
      $error("pinport: open-drain line cannot be analog-capable");
   end

   reg_sel_e         sel;
   wr_op_e           op;
   logic [WIDTH-1:0] sync_lvl;
   logic [WIDTH-1:0] pin_dig;
   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] mode_q;
   logic [WIDTH-1:0] rd_mux;

   assign sel = reg_sel_e'(addr);
   assign op  = wr_op_e'(wr_op);

   pinport_sync #(.WIDTH(WIDTH)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (sync_lvl)
   );

   assign pin_dig = sync_lvl & ~mode_q;
   assign tmr_clk = sync_lvl[OD_BIT];

   pinport_regs #(.WIDTH(WIDTH), .ANA_CAP(ANA_CAP)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .sel     (sel),
      .op      (op),
      .bitsel  (wr_bit),
      .wdata   (wr_data),
      .pin_dig (pin_dig),
      .lat_q   (lat_q),
      .dir_q   (dir_q),
      .mode_q  (mode_q)
   );

   pinport_pad #(.WIDTH(WIDTH), .OD_BIT(OD_BIT)) u_pad (
      .lat    (lat_q),
      .dir    (dir_q),
      .drv_o  (pin_o),
      .drv_oe (pin_oe)
   );

   always_comb begin
      case (sel)
         SEL_DATA: rd_mux = pin_dig;
         SEL_DIR:  rd_mux = dir_q;
         SEL_MODE: rd_mux = mode_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_mux;
   end

   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         warm_q <= '0;
      else if (warm_q != 2'd3)
         warm_q <= warm_q + 2'd1;
   end

   // R2
   oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & dir_q) == '0));

   // R7
   od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[OD_BIT] |-> (!lat_q[OD_BIT] && !dir_q[OD_BIT] && !pin_o[OD_BIT]));

   // R8
   tap_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 2'd2) |-> (tmr_clk == $past(pin_i[OD_BIT], 2)));

   // R9
   analog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_DATA) |=> ((rd_data & $past(mode_q)) == '0));

   // R3
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

// File: tb/pinport_bench.sv
module pinport_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] CAP = 6'b101111;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_op = '0;
   logic [2:0] wr_bit = '0;
   logic [5:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [5:0] rd_data;
   logic [5:0] pin_i = '0;
   logic [5:0] pin_o;
   logic [5:0] pin_oe;
   logic       tmr_clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pinport u_pinport (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_op(wr_op),
      .wr_bit(wr_bit), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .tmr_clk(tmr_clk)
   );

   task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [1:0] o, input logic [2:0] b,
                         input logic [5:0] d);
      @(negedge clk);
      addr = a; wr_op = o; wr_bit = b; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [5:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   function automatic logic [5:0] exp_o(input logic [5:0] lat);
      return lat & 6'b101111;
   endfunction

   function automatic logic [5:0] exp_oe(input logic [5:0] lat, input logic [5:0] dir);
      logic [5:0] e;
      e = ~dir;
      e[4] = ~dir[4] & ~lat[4];
      return e;
   endfunction

   task automatic chk_pads(input string tag, input logic [5:0] lat, input logic [5:0] dir);
      chk({tag, " pin_o"}, pin_o, exp_o(lat));
      chk({tag, " pin_oe"}, pin_oe, exp_oe(lat, dir));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [5:0] v;
      logic [5:0] exp_lat;
      logic [5:0] m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 rd_data", rd_data, 6'h00);
      chk("R1 pin_oe", pin_oe, 6'h00);
      chk("R1 pin_o", pin_o, 6'h00);
      bus_rd(2'd1, v); chk("R1 dir", v, 6'h3F);
      bus_rd(2'd2, v); chk("R1 mode", v, CAP);

      // R10 drivers ignore analog mode (mode still CAP after reset)
      bus_wr(2'd1, 2'd0, 3'd0, 6'h00);
      chk_pads("R10 analog outputs", 6'h00, 6'h00);
      bus_wr(2'd0, 2'd0, 3'd0, 6'h3F);
      chk_pads("R10 analog latch", 6'h3F, 6'h00);

      // R2 R5 R7 latch and direction sweep
      for (int l = 0; l < 64; l++) begin
         bus_wr(2'd0, 2'd0, 3'd0, 6'(l));
         for (int k = 0; k < 4; k++) begin
            logic [5:0] d;
            case (k)
               0: d = 6'h00;
               1: d = 6'h3F;
               2: d = 6'h15;
               default: d = ~6'(l);
            endcase
            bus_wr(2'd1, 2'd0, 3'd0, d);
            chk_pads("R2 R5 R7 sweep", 6'(l), d);
         end
      end

      // R3 address 3 reads zero and ignores writes
      bus_wr(2'd3, 2'd0, 3'd0, 6'h3F);
      bus_rd(2'd3, v); chk("R3 addr3", v, 6'h00);
      chk_pads("R3 addr3 no effect", 6'h3F, ~6'h3F);

      // R4 pin read sweep with analog mode off
      bus_wr(2'd2, 2'd0, 3'd0, 6'h00);
      bus_wr(2'd1, 2'd0, 3'd0, 6'h3F);
      for (int p = 0; p < 64; p++) begin
         @(negedge clk);
         pin_i = 6'(p);
         repeat (2) @(negedge clk);
         bus_rd(2'd0, v);
         chk("R4 pin read", v, 6'(p));
      end

      // R4 latency: read strobed in the same cycle as a pin change sees the old level
      @(negedge clk);
      pin_i = 6'h2A;
      repeat (3) @(negedge clk);
      pin_i = 6'h15; addr = 2'd0; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R4 old level", rd_data, 6'h2A);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R4 new level", rd_data, 6'h15);
      // R3 rd_data holds without a strobe
      pin_i = 6'h00;
      repeat (4) @(negedge clk);
      chk("R3 hold", rd_data, 6'h15);

      // R8 timer tap delay
      @(negedge clk);
      pin_i[4] = 1'b1;
      @(negedge clk);
      chk("R8 tap one cycle", {5'b0, tmr_clk}, 6'h00);
      @(negedge clk);
      chk("R8 tap two cycles", {5'b0, tmr_clk}, 6'h01);
      pin_i[4] = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 tap fall", {5'b0, tmr_clk}, 6'h00);

      // R9 R5 mode sweep
      @(negedge clk);
      pin_i = 6'h3F;
      repeat (2) @(negedge clk);
      for (int mm = 0; mm < 64; mm++) begin
         bus_wr(2'd2, 2'd0, 3'd0, 6'(mm));
         bus_rd(2'd2, v); chk("R5 mode mask", v, 6'(mm) & CAP);
         bus_rd(2'd0, v); chk("R9 analog read", v, 6'h3F & ~(6'(mm) & CAP));
      end

      // R6 R9 read-modify-write sweep
      m = 6'h05;
      bus_wr(2'd2, 2'd0, 3'd0, m);
      for (int pp = 0; pp < 4; pp++) begin
         logic [5:0] pat;
         case (pp)
            0: pat = 6'h2A;
            1: pat = 6'h15;
            2: pat = 6'h33;
            default: pat = 6'h0F;
         endcase
         for (int b = 0; b < 8; b++) begin
            for (int o = 1; o < 3; o++) begin
               bus_wr(2'd1, 2'd0, 3'd0, 6'h3F);
               bus_wr(2'd0, 2'd0, 3'd0, ~pat);
               @(negedge clk);
               pin_i = pat;
               repeat (2) @(negedge clk);
               bus_wr(2'd0, 2'(o), 3'(b), 6'h00);
               if (b < 6) begin
                  exp_lat = pat & ~m;
                  if (o == 1) exp_lat[b] = 1'b1;
                  else        exp_lat[b] = 1'b0;
               end else begin
                  exp_lat = ~pat;
               end
               bus_wr(2'd1, 2'd0, 3'd0, 6'h00);
               chk_pads("R6 R9 rmw", exp_lat, 6'h00);
            end
         end
      end

      // R6 set/clear on direction register, no-op code
      bus_wr(2'd1, 2'd0, 3'd0, 6'h3F);
      bus_wr(2'd1, 2'd2, 3'd2, 6'h00);
      bus_rd(2'd1, v); chk("R6 dir clear", v, 6'h3B);
      bus_wr(2'd1, 2'd1, 3'd2, 6'h00);
      bus_wr(2'd1, 2'd2, 3'd7, 6'h00);
      bus_rd(2'd1, v); chk("R6 dir set and bad index", v, 6'h3F);
      bus_wr(2'd0, 2'd0, 3'd0, 6'h21);
      bus_wr(2'd0, 2'd3, 3'd0, 6'h1E);
      bus_wr(2'd1, 2'd0, 3'd0, 6'h00);
      chk_pads("R6 nop op", 6'h21, 6'h00);

      finish_run();
   end

endmodule